// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A controller for a bank of general-purpose I/O lines, reached over a simple 16-bit register bus. Each line is set as an input or an output. Output lines drive the value held in an output latch. Input lines are captured once per clock by a sampling register, and their levels can be read back through a per-line read-enable gate.

Every line has its own edge select (rising or falling) and its own mask. An edge that matches the select, seen on an unmasked input line, sets a sticky status bit. Software clears a status bit by writing a one to it. One interrupt request is raised while any status bit is set. Only halfword (16-bit) accesses are accepted. Any other access width is reported on an error output and leaves every register as it was.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, the direction, mask and read-enable registers read 0xFFFF. The output latch, edge select and status read 0x0000. The interrupt is low and no pad is driven (pad_oe = 0).
- R2: A direction bit of 1 makes its line an input and a 0 makes it an output. pad_oe equals the inverse of the direction register. pad_out carries the latch value on output lines and 0 on input lines.
- R3: A valid write to the output latch (offset 0x04) drives the new value on every output line from the clock edge that takes the write.
- R4: A valid write to the direction register (offset 0x08) re-evaluates the pads from the clock edge that takes the write. New output lines drive their latched value; new input lines stop driving.
- R5: pad_in is captured on every clock edge. If a line's new level differs from its previous sample, its status bit is set at that same edge when the edge matches the line's select bit (offset 0x0C): 1 selects a low-to-high change, 0 selects high-to-low. A change in the other direction sets nothing.
- R6: A status bit is set only when its line has direction 1 (input) and mask bit 0 (mask register at offset 0x10). A mask bit of 1 blocks the line.
- R7: irq is high exactly when at least one status bit is set, and it changes at the same clock edge as the status register.
- R8: Writing the status register (offset 0x14) clears each bit written as 1 and leaves bits written as 0 unchanged. When an edge event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: Reading offset 0x00 returns the sampled input levels ANDed with the read-enable register (offset 0x18). The other registers read back as written. Unmapped offsets read 0, and writes to offset 0x00 change nothing.
- R10: bus_size encodes 00 = byte, 01 = halfword, 10 = word, 11 = reserved. Any access with a size other than 01 raises bus_err in the same cycle, returns 0 on bus_rdata and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational during a read access |
| bus_err | output | 1 | Access width error, combinational |
| pad_in | input | 16 | Input levels from the pads |
| pad_out | output | 16 | Output levels to the pads |
| pad_oe | output | 16 | Per-line output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data and bus_err are combinational, so the bench samples them 1 ns after putting an access on the bus, before any clock edge passes. The register writes, the pad drive (R3, R4), status bits and irq (R5 to R8) all take effect at the first rising edge after the stimulus. The bench applies each stimulus on a falling edge and samples on the next falling edge, half a period after the edge that must have acted. A full sweep covers every line with both edge selects, both directions and both mask states. Each case checks that the matching edge sets status and irq as predicted, and that the opposite edge sets nothing.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   // Register byte offsets on the bus
   localparam logic [4:0] OFS_LEVEL  = 5'h00;
   localparam logic [4:0] OFS_LATCH  = 5'h04;
   localparam logic [4:0] OFS_DIR    = 5'h08;
   localparam logic [4:0] OFS_EDGE   = 5'h0C;
   localparam logic [4:0] OFS_MASK   = 5'h10;
   localparam logic [4:0] OFS_STATUS = 5'h14;
   localparam logic [4:0] OFS_RDEN   = 5'h18;

   // Access width codes
   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
   import gpio_edge_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [LINES-1:0]  level_q,
   input  logic [LINES-1:0]  status_q,
   output logic [BUS_W-1:0]  rdata,
   output logic              err,
   output logic [LINES-1:0]  dir_q,
   output logic [LINES-1:0]  latch_q,
   output logic [LINES-1:0]  edge_q,
   output logic [LINES-1:0]  mask_q,
   output logic [LINES-1:0]  clr
);
   localparam logic [LINES-1:0] ALL_ONES = {LINES{1'b1}};

   logic              acc_ok, wr_en, rd_en;
   logic [LINES-1:0]  rden_q;
   logic [LINES-1:0]  wval;
   logic [LINES-1:0]  rd_l;

   generate
      if (LINES < 1 || LINES > BUS_W) begin : g_bad_lines
         $error("gpio_edge_regs: LINES must be within 1..BUS_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("gpio_edge_regs: ADDR_W must be at least 5");
      end
   endgenerate

   assign acc_ok = sel && (size == SZ_HALF);
   assign err    = sel && (size != SZ_HALF);
   assign wr_en  = acc_ok && wr;
   assign rd_en  = acc_ok && !wr;
   assign wval   = wdata[LINES-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q   <= ALL_ONES;
         latch_q <= '0;
         edge_q  <= '0;
         mask_q  <= ALL_ONES;
         rden_q  <= ALL_ONES;
      end else if (wr_en) begin
         if (addr == ADDR_W'(OFS_LATCH)) latch_q <= wval;
         if (addr == ADDR_W'(OFS_DIR))   dir_q   <= wval;
         if (addr == ADDR_W'(OFS_EDGE))  edge_q  <= wval;
         if (addr == ADDR_W'(OFS_MASK))  mask_q  <= wval;
         if (addr == ADDR_W'(OFS_RDEN))  rden_q  <= wval;
      end
   end

   assign clr = (wr_en && addr == ADDR_W'(OFS_STATUS)) ? wval : '0;

   always_comb begin
      rd_l = '0;
      if (rd_en) begin
         if      (addr == ADDR_W'(OFS_LEVEL))  rd_l = level_q & rden_q;
         else if (addr == ADDR_W'(OFS_LATCH))  rd_l = latch_q;
         else if (addr == ADDR_W'(OFS_DIR))    rd_l = dir_q;
         else if (addr == ADDR_W'(OFS_EDGE))   rd_l = edge_q;
         else if (addr == ADDR_W'(OFS_MASK))   rd_l = mask_q;
         else if (addr == ADDR_W'(OFS_STATUS)) rd_l = status_q;
         else if (addr == ADDR_W'(OFS_RDEN))   rd_l = rden_q;
         else                                  rd_l = '0;
      end
   end

   generate
      if (BUS_W > LINES) begin : g_rd_pad
         assign rdata = {{(BUS_W-LINES){1'b0}}, rd_l};
      end else begin : g_rd_full
         assign rdata = rd_l;
      end
   endgenerate

   AST_BAD_WIDTH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> ($stable(dir_q) && $stable(latch_q) && $stable(edge_q) && $stable(mask_q) && $stable(rden_q))); // R10

   AST_BAD_WIDTH_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (clr == '0)); // R10
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int LINES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] pad_in,
   input  logic [LINES-1:0] dir_q,
   input  logic [LINES-1:0] edge_q,
   input  logic [LINES-1:0] mask_q,
   input  logic [LINES-1:0] clr,
   output logic [LINES-1:0] level_q,
   output logic [LINES-1:0] status_q,
   output logic             irq
);
   logic [LINES-1:0] hit;
   logic [LINES-1:0] event_v;
   logic [LINES-1:0] status_n;

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         logic rise, fall;
         assign rise       = pad_in[i] & ~level_q[i];
         assign fall       = ~pad_in[i] & level_q[i];
         assign hit[i]     = edge_q[i] ? rise : fall;
         assign event_v[i] = hit[i] & dir_q[i] & ~mask_q[i];
         // a fresh event outranks a clear of the same bit
         assign status_n[i] = event_v[i] | (status_q[i] & ~clr[i]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q  <= '0;
         status_q <= '0;
         irq      <= 1'b0;
      end else begin
         level_q  <= pad_in;
         status_q <= status_n;
         irq      <= |status_n;
      end
   end

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (event_v != '0) |=> ((status_q & $past(event_v)) == $past(event_v))); // R5

   AST_BLOCKED_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ($past(mask_q) | ~$past(dir_q))) == '0)); // R6

   AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (status_q != '0)); // R7

   AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(status_q) & ~$past(clr) & ~status_q) == '0)); // R8
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
   parameter int LINES = 16
) (
   input  logic [LINES-1:0] dir_q,
   input  logic [LINES-1:0] latch_q,
   output logic [LINES-1:0] pad_out,
   output logic [LINES-1:0] pad_oe
);
   generate
      for (genvar i = 0; i < LINES; i++) begin : g_pad
         assign pad_oe[i]  = ~dir_q[i];
         assign pad_out[i] = latch_q[i] & ~dir_q[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              bus_err,
   input  logic [LINES-1:0]  pad_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe,
   output logic              irq
);
   logic [LINES-1:0] dir_q, latch_q, edge_q, mask_q, clr;
   logic [LINES-1:0] level_q, status_q;

   gpio_edge_regs #(.LINES(LINES), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bus_sel),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .size     (bus_size),
      .wdata    (bus_wdata),
      .level_q  (level_q),
      .status_q (status_q),
      .rdata    (bus_rdata),
      .err      (bus_err),
      .dir_q    (dir_q),
      .latch_q  (latch_q),
      .edge_q   (edge_q),
      .mask_q   (mask_q),
      .clr      (clr)
   );

   gpio_edge_irq #(.LINES(LINES)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .dir_q    (dir_q),
      .edge_q   (edge_q),
      .mask_q   (mask_q),
      .clr      (clr),
      .level_q  (level_q),
      .status_q (status_q),
      .irq      (irq)
   );

   gpio_pad_drive #(.LINES(LINES)) u_pads (
      .dir_q   (dir_q),
      .latch_q (latch_q),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   logic good_wr;
   assign good_wr = bus_sel && bus_wr && (bus_size == SZ_HALF);

   AST_LATCH_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && bus_addr == ADDR_W'(OFS_LATCH)) |=>
         (pad_out == ($past(bus_wdata[LINES-1:0]) & ~dir_q))); // R3

   AST_DIR_WRITE_REDRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && bus_addr == ADDR_W'(OFS_DIR)) |=>
         ((pad_oe == ~$past(bus_wdata[LINES-1:0])) &&
          (pad_out == (latch_q & ~$past(bus_wdata[LINES-1:0]))))); // R4

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!irq && pad_oe == '0)); // R1
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'b01;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_err;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = 2'b01; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = 2'b01;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [4:0] a, input logic [15:0] exp);
      logic [15:0] v;
      @(negedge clk);
      rd(a, v);
      chk(req, v, exp);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      rdchk("R1 dir", 5'h08, 16'hFFFF);
      rdchk("R1 mask", 5'h10, 16'hFFFF);
      rdchk("R1 rden", 5'h18, 16'hFFFF);
      rdchk("R1 latch", 5'h04, 16'h0000);
      rdchk("R1 edge", 5'h0C, 16'h0000);
      rdchk("R1 status", 5'h14, 16'h0000);
      chk("R1 irq", {15'd0, irq}, 16'h0000);
      chk("R1 pad_oe", pad_oe, 16'h0000);
      chk("R1 pad_out", pad_out, 16'h0000);

      // R2, R3: latch write drives output lines only
      wr(5'h08, 16'h00FF);
      chk("R2 pad_oe", pad_oe, 16'hFF00);
      wr(5'h04, 16'hA5C3);
      chk("R3 pad_out", pad_out, 16'hA5C3 & 16'hFF00);
      rdchk("R2 latch readback", 5'h04, 16'hA5C3);

      // R4: direction change re-drives the latch
      wr(5'h08, 16'hFF00);
      chk("R4 pad_oe", pad_oe, 16'h00FF);
      chk("R4 pad_out", pad_out, 16'hA5C3 & 16'h00FF);

      // R9: input read gated by read-enable, write to 0x00 ignored, unmapped reads 0
      pad_in = 16'h1234;
      @(negedge clk);
      rdchk("R9 level all enabled", 5'h00, 16'h1234);
      wr(5'h18, 16'h0F0F);
      rdchk("R9 level gated", 5'h00, 16'h1234 & 16'h0F0F);
      wr(5'h00, 16'hFFFF);
      rdchk("R9 level after write", 5'h00, 16'h1234 & 16'h0F0F);
      rdchk("R9 latch untouched", 5'h04, 16'hA5C3);
      chk("R9 pad_out untouched", pad_out, 16'hA5C3 & 16'h00FF);
      rdchk("R9 unmapped", 5'h1C, 16'h0000);
      wr(5'h18, 16'hFFFF);

      // R10: bad widths
      for (int s = 0; s < 4; s++) begin
         if (s != 1) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h08; bus_size = 2'(s); bus_wdata = 16'h0000;
            #1 chk("R10 err on bad write", {15'd0, bus_err}, 16'h0001);
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0; bus_size = 2'b01;
            rdchk("R10 dir unchanged", 5'h08, 16'hFF00);
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h08; bus_size = 2'(s);
            #1 chk("R10 bad read data", bus_rdata, 16'h0000);
            bus_sel = 1'b0; bus_size = 2'b01;
         end
      end
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h08; bus_size = 2'b01;
      #1 chk("R10 no err on halfword", {15'd0, bus_err}, 16'h0000);
      bus_sel = 1'b0;

      // R7, R8: partial write-one-to-clear
      pad_in = 16'h0000;
      wr(5'h08, 16'hFFFF);
      wr(5'h0C, 16'h0028);
      wr(5'h10, 16'hFFD7);
      wr(5'h14, 16'hFFFF);
      @(negedge clk);
      pad_in = 16'h0028;
      @(negedge clk);
      rdchk("R5 two rising", 5'h14, 16'h0028);
      chk("R7 irq set", {15'd0, irq}, 16'h0001);
      wr(5'h14, 16'h0008);
      rdchk("R8 partial clear", 5'h14, 16'h0020);
      chk("R7 irq still set", {15'd0, irq}, 16'h0001);
      wr(5'h14, 16'h0020);
      rdchk("R8 full clear", 5'h14, 16'h0000);
      chk("R7 irq dropped", {15'd0, irq}, 16'h0000);

      // R8: edge and clear in the same cycle, edge wins
      pad_in = 16'h0000;
      @(negedge clk);
      wr(5'h14, 16'hFFFF);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h14; bus_size = 2'b01; bus_wdata = 16'h0008;
      pad_in = 16'h0008;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      rdchk("R8 edge beats clear", 5'h14, 16'h0008);
      chk("R8 irq with edge", {15'd0, irq}, 16'h0001);
      pad_in = 16'h0000;
      wr(5'h14, 16'hFFFF);

      // R5, R6, R7: sweep every line over edge select, direction, mask
      for (int i = 0; i < 16; i++) begin
         for (int c = 0; c < 8; c++) begin
            logic eb, db, mb, act;
            logic [15:0] bit_i, exp;
            eb = c[0]; db = c[1]; mb = c[2];
            bit_i = 16'h0001 << i;
            act = eb;
            wr(5'h08, db ? 16'hFFFF : ~bit_i);
            wr(5'h10, mb ? 16'hFFFF : ~bit_i);
            wr(5'h0C, eb ? bit_i : 16'h0000);
            pad_in = act ? 16'h0000 : bit_i;
            @(negedge clk);
            @(negedge clk);
            wr(5'h14, 16'hFFFF);
            pad_in = act ? bit_i : 16'h0000;
            @(negedge clk);
            exp = (db && !mb) ? bit_i : 16'h0000;
            rdchk(db ? (mb ? "R6 masked input" : "R5 matching edge") : "R6 output line", 5'h14, exp);
            chk("R7 irq follows status", {15'd0, irq}, {15'd0, (exp != 16'h0000)});
            wr(5'h14, 16'hFFFF);
            pad_in = act ? 16'h0000 : bit_i;
            @(negedge clk);
            rdchk("R5 opposite edge ignored", 5'h14, 16'h0000);
            chk("R7 irq low on opposite edge", {15'd0, irq}, 16'h0000);
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule